// File: doc/BRIEF.md
# Bidirectional Bus Transceiver with Parity Generator and Checker

This block joins two parallel data ports, A and B, through a non-inverting transceiver whose direction is chosen by a single control input. When transmitting, data seen on port A is driven out on port B, and a parity bit computed over all of port A is driven on a bidirectional parity pin. When receiving, data seen on port B is driven out on port A. The parity pin then acts as an input, and a status output compares it with the parity of port B.

A single active-low output enable releases every pad at once. The status output is active-low: high means the parity agrees and low means a parity error. It is only driven while receiving. A select input chooses odd or even parity for both generation and checking. Each bidirectional pad is modelled as three signals: a sampled input, a driven output value and an output enable. A pad wrapper outside the block joins them. The block is purely combinational and has no clock or reset. Parity covers the full parameterised data width.

Top module: `parity_bus_xcvr`

## Requirements
- R1: With `oe_n_i` low and `dir_tx_i` high (transmit), `b_oe_o` is 1 and `b_out_o` equals `a_in_i` bit for bit, without inversion.
- R2: With `oe_n_i` low and `dir_tx_i` low (receive), `a_oe_o` is 1 and `a_out_o` equals `b_in_i` bit for bit, without inversion.
- R3: With `oe_n_i` high, `a_oe_o`, `b_oe_o`, `par_oe_o` and `err_oe_o` are all 0, whatever the value of `dir_tx_i`.
- R4: In transmit with outputs enabled, `par_oe_o` is 1 and `par_out_o` equals `odd_sel_i` XOR the XOR of all bits of `a_in_i`. For example, with `odd_sel_i` = 1 and an even number of ones on A, it is 1.
- R5: In receive with outputs enabled, `err_oe_o` is 1 and `err_n_o` equals NOT(XOR of all bits of `b_in_i` XOR `odd_sel_i` XOR `par_in_i`). For example, with an even count on B, select 1 and parity-in 1, it is 1 (no error). With an odd count and the same settings, it is 0 (error).
- R6: The two ports are never enabled together. In transmit, `a_oe_o` and `err_oe_o` are 0. In receive, `b_oe_o` and `par_oe_o` are 0.
- R7: Any output value whose enable is 0 reads as all zeros: `a_out_o`, `b_out_o`, `par_out_o` and `err_n_o`.
- R8: Parity spans every bit of the data width. Changing only the most significant data bit inverts `par_out_o` in transmit and `err_n_o` in receive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| oe_n_i | input | 1 | Active-low output enable for all pads |
| dir_tx_i | input | 1 | 1 = transmit A to B, 0 = receive B to A |
| odd_sel_i | input | 1 | Parity select used for generation and checking |
| a_in_i | input | WIDTH | Sampled value of port A pads |
| a_out_o | output | WIDTH | Value driven on port A pads |
| a_oe_o | output | 1 | Drive enable for port A pads |
| b_in_i | input | WIDTH | Sampled value of port B pads |
| b_out_o | output | WIDTH | Value driven on port B pads |
| b_oe_o | output | 1 | Drive enable for port B pads |
| par_in_i | input | 1 | Sampled value of the parity pad |
| par_out_o | output | 1 | Value driven on the parity pad |
| par_oe_o | output | 1 | Drive enable for the parity pad |
| err_n_o | output | 1 | Parity status, 1 = agree, 0 = error |
| err_oe_o | output | 1 | Drive enable for the status pad |

## Verification
The bound checks assume every input holds a defined 0 or 1. They also assume the pad wrapper returns a driven pad value only on the matching input, so there is no feedback loop from an output back into its own input. The stimulus applies all control, select and data inputs as one packed word in a single update, so no half-changed input set is ever presented. It sweeps every data value against each combination of enable, direction, select and parity-in. Port B is driven with the complement of port A, so any crossed data path stands out.

// File: rtl/parity_bus_xcvr_pkg.sv
// Package: shared mode type and its decode for the parity transceiver.
// Assumes control inputs are known 0/1 values.
package parity_bus_xcvr_pkg;

    typedef enum logic [1:0] {
        XM_IDLE = 2'd0,
        XM_TX   = 2'd1,
        XM_RX   = 2'd2
    } xcvr_mode_e;

    // Maps the active-low enable and the direction bit onto a mode.
    function automatic xcvr_mode_e decode_mode(input logic oe_n, input logic dir_tx);
        if (oe_n)        return XM_IDLE;
        else if (dir_tx) return XM_TX;
        else             return XM_RX;
    endfunction

endpackage

// File: rtl/xcvr_parity_tree.sv
// Module: balanced XOR reduction tree over a WIDTH-bit vector.
// Assumes WIDTH >= 1. The input is zero-padded to a power of two, so the
// depth is clog2(WIDTH) XOR levels.
module xcvr_parity_tree #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] data_i,
    output logic             parity_o
);
    localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;
    localparam int PADDED = 1 << LEVELS;

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int N = PADDED >> l;
        logic [N-1:0] v;
        if (l == 0) begin : g_leaf
            // Leaf level: zero-extended input bits.
            assign v = N'(data_i);
        end else begin : g_node
            // Inner level: pairwise XOR of the level below.
            for (genvar i = 0; i < N; i++) begin : g_pair
                assign v[i] = g_lvl[l-1].v[2*i] ^ g_lvl[l-1].v[2*i+1];
            end
        end
    end

    assign parity_o = g_lvl[LEVELS].v[0];

endmodule

// File: rtl/xcvr_dir_ctrl.sv
// Module: turns the enable and direction inputs into per-pad drive enables.
// Assumes exactly one of transmit or receive applies when enabled.
module xcvr_dir_ctrl
    import parity_bus_xcvr_pkg::*;
(
    input  logic oe_n_i,
    input  logic dir_tx_i,
    output logic a_oe_o,
    output logic b_oe_o,
    output logic par_oe_o,
    output logic err_oe_o
);
    xcvr_mode_e mode;

    // Decode the operating mode, then derive the enables from it.
    always_comb begin
        mode     = decode_mode(oe_n_i, dir_tx_i);
        a_oe_o   = (mode == XM_RX);
        b_oe_o   = (mode == XM_TX);
        par_oe_o = (mode == XM_TX);
        err_oe_o = (mode == XM_RX);
    end

endmodule

// File: rtl/xcvr_data_steer.sv
// Module: forms the pad output values from the data, the parity results
// and the enables. Any value whose enable is low is forced to zero.
// Assumes the parity bits come from full-width reduction trees.
module xcvr_data_steer #(
    parameter int WIDTH = 8
) (
    input  logic             a_oe_i,
    input  logic             b_oe_i,
    input  logic             par_oe_i,
    input  logic             err_oe_i,
    input  logic             odd_sel_i,
    input  logic             par_in_i,
    input  logic             a_parity_i,
    input  logic             b_parity_i,
    input  logic [WIDTH-1:0] a_in_i,
    input  logic [WIDTH-1:0] b_in_i,
    output logic [WIDTH-1:0] a_out_o,
    output logic [WIDTH-1:0] b_out_o,
    output logic             par_out_o,
    output logic             err_n_o
);
    // Data paths: straight copy to the far port, gated by its enable.
    always_comb begin
        a_out_o = a_oe_i ? b_in_i : '0;
        b_out_o = b_oe_i ? a_in_i : '0;
    end

    // Parity paths: generation on transmit, active-low check on receive.
    always_comb begin
        par_out_o = par_oe_i & (odd_sel_i ^ a_parity_i);
        err_n_o   = err_oe_i & ~(b_parity_i ^ odd_sel_i ^ par_in_i);
    end

endmodule

// File: rtl/parity_bus_xcvr.sv
// Module: top of the bidirectional transceiver with parity generate/check.
// Purely combinational. Each bidirectional pad is split into in, out and
// enable signals for an external pad wrapper.
module parity_bus_xcvr #(
    parameter int WIDTH = 8
) (
    input  logic             oe_n_i,
    input  logic             dir_tx_i,
    input  logic             odd_sel_i,
    input  logic [WIDTH-1:0] a_in_i,
    output logic [WIDTH-1:0] a_out_o,
    output logic             a_oe_o,
    input  logic [WIDTH-1:0] b_in_i,
    output logic [WIDTH-1:0] b_out_o,
    output logic             b_oe_o,
    input  logic             par_in_i,
    output logic             par_out_o,
    output logic             par_oe_o,
    output logic             err_n_o,
    output logic             err_oe_o
);
    logic a_parity;
    logic b_parity;

    xcvr_dir_ctrl u_ctrl (
        .oe_n_i   (oe_n_i),
        .dir_tx_i (dir_tx_i),
        .a_oe_o   (a_oe_o),
        .b_oe_o   (b_oe_o),
        .par_oe_o (par_oe_o),
        .err_oe_o (err_oe_o)
    );

    xcvr_parity_tree #(.WIDTH(WIDTH)) u_par_a (
        .data_i   (a_in_i),
        .parity_o (a_parity)
    );

    xcvr_parity_tree #(.WIDTH(WIDTH)) u_par_b (
        .data_i   (b_in_i),
        .parity_o (b_parity)
    );

    xcvr_data_steer #(.WIDTH(WIDTH)) u_steer (
        .a_oe_i     (a_oe_o),
        .b_oe_i     (b_oe_o),
        .par_oe_i   (par_oe_o),
        .err_oe_i   (err_oe_o),
        .odd_sel_i  (odd_sel_i),
        .par_in_i   (par_in_i),
        .a_parity_i (a_parity),
        .b_parity_i (b_parity),
        .a_in_i     (a_in_i),
        .b_in_i     (b_in_i),
        .a_out_o    (a_out_o),
        .b_out_o    (b_out_o),
        .par_out_o  (par_out_o),
        .err_n_o    (err_n_o)
    );

endmodule

// File: rtl/parity_bus_xcvr_chk.sv
// Checker: port-level rules for the parity transceiver, bound to the top.
// Assumes known input values. Immediate checks, since the block has no clock.
module parity_bus_xcvr_chk #(
    parameter int WIDTH = 8
) (
    input logic             oe_n_i,
    input logic             dir_tx_i,
    input logic             odd_sel_i,
    input logic [WIDTH-1:0] a_in_i,
    input logic [WIDTH-1:0] a_out_o,
    input logic             a_oe_o,
    input logic [WIDTH-1:0] b_in_i,
    input logic [WIDTH-1:0] b_out_o,
    input logic             b_oe_o,
    input logic             par_in_i,
    input logic             par_out_o,
    input logic             par_oe_o,
    input logic             err_n_o,
    input logic             err_oe_o
);
    // Check every rule whenever any observed signal changes.
    always_comb begin
        if (!oe_n_i && dir_tx_i)
            assert_tx_path_R1: assert (b_oe_o && b_out_o == a_in_i);
        if (!oe_n_i && !dir_tx_i)
            assert_rx_path_R2: assert (a_oe_o && a_out_o == b_in_i);
        if (oe_n_i)
            assert_all_float_R3: assert (!a_oe_o && !b_oe_o && !par_oe_o && !err_oe_o);
        if (!oe_n_i && dir_tx_i)
            assert_par_gen_R4: assert (par_oe_o && par_out_o == (odd_sel_i ^ (^a_in_i)));
        if (!oe_n_i && !dir_tx_i)
            assert_par_chk_R5: assert (err_oe_o && err_n_o == ~((^b_in_i) ^ odd_sel_i ^ par_in_i));
        assert_port_excl_R6: assert ($countones({a_oe_o, b_oe_o}) <= 1);
        if (dir_tx_i)
            assert_tx_quiet_R6: assert (!a_oe_o && !err_oe_o);
        else
            assert_rx_quiet_R6: assert (!b_oe_o && !par_oe_o);
        assert_zero_idle_R7: assert ((a_oe_o || a_out_o == '0) && (b_oe_o || b_out_o == '0)
                                     && (par_oe_o || !par_out_o) && (err_oe_o || !err_n_o));
    end

endmodule

bind parity_bus_xcvr parity_bus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/parity_bus_xcvr_tb_top.sv
// Bench: table of directed vectors, then a full sweep of data, select,
// parity-in, direction and enable, with an independent reference model.
module parity_bus_xcvr_tb_top;
    localparam int W = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    // Packed stimulus, applied in one update: {oe_n, dir, sel, par_in, a, b}.
    logic [2*W+3:0] stim = '0;

    logic [W-1:0] a_out, b_out;
    logic a_oe, b_oe, par_out, par_oe, err_n, err_oe;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    parity_bus_xcvr #(.WIDTH(W)) dut_i (
        .oe_n_i    (stim[2*W+3]),
        .dir_tx_i  (stim[2*W+2]),
        .odd_sel_i (stim[2*W+1]),
        .par_in_i  (stim[2*W]),
        .a_in_i    (stim[2*W-1:W]),
        .b_in_i    (stim[W-1:0]),
        .a_out_o   (a_out),
        .a_oe_o    (a_oe),
        .b_out_o   (b_out),
        .b_oe_o    (b_oe),
        .par_out_o (par_out),
        .par_oe_o  (par_oe),
        .err_n_o   (err_n),
        .err_oe_o  (err_oe)
    );

    // Directed vectors: {oe_n,dir,sel,par, a, b, a_oe,b_oe,p_oe,e_oe, par_out, err_n}
    localparam logic [25:0] VEC [11] = '{
        {4'b0110, 8'h00, 8'h5A, 4'b0110, 1'b1, 1'b0},  // tx even, sel1 -> 1
        {4'b0110, 8'h01, 8'h5A, 4'b0110, 1'b0, 1'b0},  // tx odd, sel1 -> 0
        {4'b0100, 8'h03, 8'hC3, 4'b0110, 1'b0, 1'b0},  // tx even, sel0 -> 0
        {4'b0100, 8'h07, 8'hC3, 4'b0110, 1'b1, 1'b0},  // tx odd, sel0 -> 1
        {4'b0100, 8'h80, 8'h00, 4'b0110, 1'b1, 1'b0},  // msb alone counts
        {4'b0011, 8'hFF, 8'h03, 4'b1001, 1'b0, 1'b1},  // rx even,s1,p1 ok
        {4'b0011, 8'hFF, 8'h01, 4'b1001, 1'b0, 1'b0},  // rx odd,s1,p1 error
        {4'b0001, 8'h00, 8'h00, 4'b1001, 1'b0, 1'b0},  // rx even,s0,p1 error
        {4'b0000, 8'h00, 8'h00, 4'b1001, 1'b0, 1'b1},  // rx even,s0,p0 ok
        {4'b1111, 8'hAA, 8'h55, 4'b0000, 1'b0, 1'b0},  // disabled, tx
        {4'b1011, 8'hAA, 8'h55, 4'b0000, 1'b0, 1'b0}   // disabled, rx
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Applies one stimulus word right after a rising edge; sampling is at the falling edge.
    task automatic apply(input logic [2*W+3:0] s);
        @(posedge clk);
        stim = s;
        @(negedge clk);
    endtask

    // Independent model of one stimulus word against the requirements.
    task automatic model_check(input logic [2*W+3:0] s);
        logic oe_n, dir, sel, pin, tx, rx;
        logic [W-1:0] a, b;
        int ones_a, ones_b;
        oe_n = s[2*W+3]; dir = s[2*W+2]; sel = s[2*W+1]; pin = s[2*W];
        a = s[2*W-1:W]; b = s[W-1:0];
        tx = !oe_n && dir; rx = !oe_n && !dir;
        ones_a = 0; ones_b = 0;
        for (int i = 0; i < W; i++) begin
            ones_a += a[i];
            ones_b += b[i];
        end
        check({a_oe, b_oe, par_oe, err_oe} == {rx, tx, tx, rx}, "R3/R6 enables",
              {a_oe, b_oe, par_oe, err_oe}, {rx, tx, tx, rx});
        check(b_out == (tx ? a : '0), "R1/R7 b_out", b_out, tx ? a : '0);
        check(a_out == (rx ? b : '0), "R2/R7 a_out", a_out, rx ? b : '0);
        check(par_out == (tx & (sel ^ ones_a[0])), "R4/R7 par_out", par_out, tx & (sel ^ ones_a[0]));
        check(err_n == (rx & ~(ones_b[0] ^ sel ^ pin)), "R5/R7 err_n", err_n, rx & ~(ones_b[0] ^ sel ^ pin));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // Initial state with all pads released (R3).
        apply({1'b1, 1'b0, 1'b0, 1'b0, {W{1'b0}}, {W{1'b0}}});
        check({a_oe, b_oe, par_oe, err_oe} == 4'b0000, "R3 initial float", {a_oe, b_oe, par_oe, err_oe}, 0);

        // Directed table.
        for (int v = 0; v < 11; v++) begin
            apply(VEC[v][25:6]);
            check(VEC[v][5:2] == {a_oe, b_oe, par_oe, err_oe}, "R3/R6 table enables",
                  {a_oe, b_oe, par_oe, err_oe}, VEC[v][5:2]);
            check(VEC[v][1] == par_out, "R4 table parity", par_out, VEC[v][1]);
            check(VEC[v][0] == err_n, "R5 table error", err_n, VEC[v][0]);
        end

        // Full sweep: B carries the complement of A, so crossed paths show.
        for (int ctl = 0; ctl < 16; ctl++) begin
            for (int d = 0; d < 256; d++) begin
                logic [2*W+3:0] s;
                s = {ctl[3:0], W'(d), ~W'(d)};
                apply(s);
                model_check(s);
            end
        end

        // R8: MSB alone flips the transmit parity and the receive status.
        apply({4'b0100, 8'h00, 8'h00});
        begin
            logic p0;
            p0 = par_out;
            apply({4'b0100, 8'h80, 8'h00});
            check(par_out == ~p0, "R8 msb tx", par_out, ~p0);
        end
        apply({4'b0000, 8'h00, 8'h00});
        begin
            logic e0;
            e0 = err_n;
            apply({4'b0000, 8'h00, 8'h80});
            check(err_n == ~e0, "R8 msb rx", err_n, ~e0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule